// File: doc/BRIEF.md
# Hash Engine Command and Status Register Block

This block is the software-facing register file of a hash accelerator. A 32-bit, word-addressed write/read port reaches a small set of registers. These hold the message source pointer, the digest destination pointer, the key pointer, the message length, a cipher command word and the hash command word. Each register has its own write mask. The hash datapath and its memory master sit outside the block. A `eng_done` input and an `eng_busy` input stand in for them.

Writing the hash command word decodes the algorithm selection in that word. If the selection is legal and the engine is idle, the block issues a one-cycle start pulse on the next cycle. The pulse carries the decoded algorithm code, the scatter-gather flag and the accumulate flag. When the engine reports completion, a completion bit is set in the status word. The interrupt line is raised only if the command word enables it. Software acknowledges completion by writing a one to the completion bit.

Top module: `hashreg_top`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `start` is 0.
- R2: A write to word 12 (hash command) with a legal selection while `eng_busy`=0 makes `start` high for exactly the next cycle. `start_sg` equals command bit 18. `start_acc` is 1 only when command bits [8:7] equal 2'b10.
- R3: Command bits [6:4] select the algorithm, giving these `start_algo` codes: 000 gives MD5=0, 010 gives SHA-1=1, 100 gives SHA-224=2, 101 gives SHA-256=3. The values 001, 110 and 111 are illegal.
- R4: When bits [6:4]=011, bits [12:10] pick the variant: 000 gives SHA-512=4, 001 gives SHA-384=5, 010 gives SHA-256=3. Any other variant value is illegal. An illegal selection issues no start, but the command word is still stored.
- R5: An `eng_done` pulse sets status bit 9 on the next cycle, whatever the state of command bit 9. `irq` rises at that same point only if command bit 9 is 1.
- R6: A write to word 7 (status) stores the data with bit 9 forced to 0. If the written bit 9 is 1, `irq` drops on the next cycle. A completion in the same cycle wins over the clear.
- R7: Word 11 (length) keeps bits [27:0]. Word 9 (destination) is masked by `DST_MASK` (default 0x7FFFFFF8, 8-byte aligned). Word 8 (source) is masked by `SRC_MASK` (default 0x7FFFFFFF). Word 10 (key) is masked by `KEY_MASK` (default 0x7FFFFFF8).
- R8: The hash command word is masked by the parameter `CMD_MASK` (default 0x00147FFF). Bits outside the mask read back as 0 and take no part in decoding.
- R9: A write to word 4 (cipher command) is stored unmasked and issues no start.
- R10: Word addresses at or above `NUM_REGS` (default 16) read as 0. Writes to them change no register, including the in-range word whose low address bits they share.
- R11: A hash command write made while `eng_busy`=1 is stored but issues no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, already synchronized on release |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| eng_busy | input | 1 | Datapath is running |
| eng_done | input | 1 | Datapath completion pulse |
| start | output | 1 | One-cycle start pulse to the datapath |
| start_algo | output | 3 | Decoded algorithm code, valid while `start` is high |
| start_sg | output | 1 | Scatter-gather enable, valid while `start` is high |
| start_acc | output | 1 | Accumulate mode, valid while `start` is high |
| irq | output | 1 | Level interrupt |

## Verification
Register contents show on `rdata` in the cycle after the write edge, because the read path is combinational from the flops. The start pulse and its attributes appear for one cycle after the edge that takes the command write. Status bit 9 and `irq` respond one edge after `eng_done` or after a status write. The bench drives every input on the falling edge, lets one rising edge pass, and samples shortly after the next falling edge. It then confirms that `start` has returned low one cycle later.

// File: rtl/hashreg_pkg.sv
package hashreg_pkg;
  localparam int DW = 32;

  // word indices of the registers that software uses
  localparam int IDX_CIPHER = 4;
  localparam int IDX_STATUS = 7;
  localparam int IDX_SRC    = 8;
  localparam int IDX_DST    = 9;
  localparam int IDX_KEY    = 10;
  localparam int IDX_LEN    = 11;
  localparam int IDX_CMD    = 12;

  localparam int DONE_BIT  = 9;
  localparam int IRQEN_BIT = 9;
  localparam int SG_BIT    = 18;

  localparam logic [DW-1:0] LEN_MASK = 32'h0FFF_FFFF;

  typedef enum logic [2:0] {
    ALG_MD5    = 3'd0,
    ALG_SHA1   = 3'd1,
    ALG_SHA224 = 3'd2,
    ALG_SHA256 = 3'd3,
    ALG_SHA512 = 3'd4,
    ALG_SHA384 = 3'd5
  } algo_e;
endpackage

// File: rtl/hashreg_algo_dec.sv
module hashreg_algo_dec
  import hashreg_pkg::*;
(
  input  logic [2:0] sel_pri,
  input  logic [2:0] sel_var,
  input  logic [1:0] sel_mode,
  input  logic       sel_sg,
  output logic       legal,
  output logic [2:0] algo,
  output logic       sg,
  output logic       acc
);
  always_comb begin
    legal = 1'b1;
    algo  = ALG_MD5;
    unique case (sel_pri)
      3'b000: algo = ALG_MD5;
      3'b010: algo = ALG_SHA1;
      3'b100: algo = ALG_SHA224;
      3'b101: algo = ALG_SHA256;
      3'b011: begin
        unique case (sel_var)
          3'b000:  algo = ALG_SHA512;
          3'b001:  algo = ALG_SHA384;
          3'b010:  algo = ALG_SHA256;
          default: legal = 1'b0;
        endcase
      end
      default: legal = 1'b0;
    endcase
  end

  assign sg  = sel_sg;
  assign acc = (sel_mode == 2'b10);
endmodule

// File: rtl/hashreg_status.sv
module hashreg_status
  import hashreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stat,
  input  logic [DW-1:0] wdata,
  input  logic          done,
  input  logic          irq_en,
  output logic [DW-1:0] stat_q,
  output logic          irq
);
  logic [DW-1:0] stat_d;
  logic          irq_q, irq_d;

  always_comb begin
    stat_d = stat_q;
    irq_d  = irq_q;
    if (wr_stat) begin
      stat_d           = wdata;
      stat_d[DONE_BIT] = 1'b0;
      if (wdata[DONE_BIT]) irq_d = 1'b0;
    end
    if (done) begin
      stat_d[DONE_BIT] = 1'b1;
      if (irq_en) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;

  p_done_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> stat_q[DONE_BIT]);
  p_irq_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done && irq_en));
  p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[DONE_BIT] && !done) |=> !irq);
endmodule

// File: rtl/hashreg_top.sv
module hashreg_top
  import hashreg_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          NUM_REGS = 16,
  parameter logic [31:0] SRC_MASK = 32'h7FFF_FFFF,
  parameter logic [31:0] DST_MASK = 32'h7FFF_FFF8,
  parameter logic [31:0] KEY_MASK = 32'h7FFF_FFF8,
  parameter logic [31:0] CMD_MASK = 32'h0014_7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              eng_busy,
  input  logic              eng_done,
  output logic              start,
  output logic [2:0]        start_algo,
  output logic              start_sg,
  output logic              start_acc,
  output logic              irq
);
  function automatic logic [DW-1:0] mask_of(input int idx);
    if (idx == IDX_SRC) return SRC_MASK;
    if (idx == IDX_DST) return DST_MASK;
    if (idx == IDX_KEY) return KEY_MASK;
    if (idx == IDX_LEN) return LEN_MASK;
    if (idx == IDX_CMD) return CMD_MASK;
    return '1;
  endfunction

  logic [NUM_REGS-1:0] hit;
  logic [DW-1:0]       reg_q [NUM_REGS];
  logic [DW-1:0]       stat_q;
  logic [DW-1:0]       cmd_new;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) hit[i] = wr_en && (int'(addr) == i);
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == IDX_STATUS) begin : g_stat
      assign reg_q[i] = stat_q;
    end else begin : g_plain
      logic [DW-1:0] q, d;
      always_comb d = hit[i] ? (wdata & mask_of(i)) : q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (hit[i]) q <= d;
      end
      assign reg_q[i] = q;
    end
  end

  hashreg_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stat(hit[IDX_STATUS]),
    .wdata  (wdata),
    .done   (eng_done),
    .irq_en (reg_q[IDX_CMD][IRQEN_BIT]),
    .stat_q (stat_q),
    .irq    (irq)
  );

  // decode the command as it is written
  logic       dec_legal, dec_sg, dec_acc;
  logic [2:0] dec_algo;
  assign cmd_new = wdata & CMD_MASK;

  hashreg_algo_dec u_dec (
    .sel_pri (cmd_new[6:4]),
    .sel_var (cmd_new[12:10]),
    .sel_mode(cmd_new[8:7]),
    .sel_sg  (cmd_new[SG_BIT]),
    .legal   (dec_legal),
    .algo    (dec_algo),
    .sg      (dec_sg),
    .acc     (dec_acc)
  );

  logic       start_d, start_q, sg_q, acc_q;
  logic [2:0] algo_q;
  assign start_d = hit[IDX_CMD] && dec_legal && !eng_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      algo_q  <= '0;
      sg_q    <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      if (start_d) begin
        algo_q <= dec_algo;
        sg_q   <= dec_sg;
        acc_q  <= dec_acc;
      end
    end
  end

  assign start      = start_q;
  assign start_algo = algo_q;
  assign start_sg   = sg_q;
  assign start_acc  = acc_q;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(addr) == i) rdata = reg_q[i];
  end

  p_start_from_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(wr_en && int'(addr) == IDX_CMD));
  p_no_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == IDX_CMD && eng_busy) |=> !start);
  p_oob_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) >= NUM_REGS) |-> (rdata == '0));
  p_cipher_nostart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == IDX_CIPHER) |=> !start);
endmodule

// File: tb/hashreg_top_tb_top.sv
module hashreg_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        eng_busy = 1'b0, eng_done = 1'b0;
  logic        start, start_sg, start_acc, irq;
  logic [2:0]  start_algo;
  int          errors = 0, checks = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  hashreg_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .eng_busy(eng_busy), .eng_done(eng_done), .start(start),
    .start_algo(start_algo), .start_sg(start_sg), .start_acc(start_acc), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 6'(a);
    #1;
    d = rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    #1;
  endtask

  // start expected right after wr returns, gone one cycle later
  task automatic cmd_start(input string req, input logic [31:0] cmd,
                           input logic [2:0] algo, input logic sg, input logic acc);
    wr(12, cmd);
    check({req, " start"}, 32'(start), 32'd1);
    check({req, " algo"}, 32'(start_algo), 32'(algo));
    check({req, " sg"}, 32'(start_sg), 32'(sg));
    check({req, " acc"}, 32'(start_acc), 32'(acc));
    @(negedge clk); #1;
    check({req, " pulse width"}, 32'(start), 32'd0);
  endtask

  task automatic cmd_nostart(input string req, input logic [31:0] cmd, input logic [31:0] readback);
    logic [31:0] v;
    wr(12, cmd);
    check({req, " no start"}, 32'(start), 32'd0);
    rd(12, v);
    check({req, " stored"}, v, readback);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin
      rd(i, v);
      check("R1 reg zero", v, 32'd0);
    end
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 start", 32'(start), 32'd0);
  endtask

  task automatic t_masks();
    logic [31:0] v;
    wr(8, 32'hFFFF_FFFF);  rd(8, v);  check("R7 src", v, 32'h7FFF_FFFF);
    wr(9, 32'hFFFF_FFFF);  rd(9, v);  check("R7 dst", v, 32'h7FFF_FFF8);
    wr(10, 32'hFFFF_FFFF); rd(10, v); check("R7 key", v, 32'h7FFF_FFF8);
    wr(11, 32'hFFFF_FFFF); rd(11, v); check("R7 len", v, 32'h0FFF_FFFF);
  endtask

  task automatic t_primary();
    cmd_start("R3 md5",    32'h0000_0000, 3'd0, 1'b0, 1'b0);
    cmd_start("R3 sha1",   32'h0000_0020, 3'd1, 1'b0, 1'b0);
    cmd_start("R3 sha224", 32'h0000_0040, 3'd2, 1'b0, 1'b0);
    cmd_start("R3 sha256", 32'h0000_0050, 3'd3, 1'b0, 1'b0);
    cmd_start("R2 sg+acc", 32'h0004_0150, 3'd3, 1'b1, 1'b1);
    cmd_start("R2 hmac not acc", 32'h0000_00A0, 3'd1, 1'b0, 1'b0);
    cmd_nostart("R3 illegal 001", 32'h0000_0010, 32'h0000_0010);
  endtask

  task automatic t_family();
    cmd_start("R4 sha512", 32'h0000_0030, 3'd4, 1'b0, 1'b0);
    cmd_start("R4 sha384", 32'h0000_0430, 3'd5, 1'b0, 1'b0);
    cmd_start("R4 sha256v", 32'h0000_0830, 3'd3, 1'b0, 1'b0);
    cmd_nostart("R4 illegal variant", 32'h0000_0C30, 32'h0000_0C30);
    cmd_nostart("R8 cmd mask", 32'hFFFF_FFFF, 32'h0014_7FFF);
  endtask

  task automatic t_done();
    logic [31:0] v;
    wr(12, 32'h0000_0020);
    pulse_done();
    rd(7, v); check("R5 done bit w/o irq en", v, 32'h0000_0200);
    check("R5 irq stays low", 32'(irq), 32'd0);
    wr(7, 32'h0000_0200);
    rd(7, v); check("R6 clear", v, 32'd0);
    wr(12, 32'h0000_0220);
    pulse_done();
    rd(7, v); check("R5 done bit with irq en", v, 32'h0000_0200);
    check("R5 irq high", 32'(irq), 32'd1);
    wr(7, 32'h0000_0005);
    rd(7, v); check("R6 store other bits", v, 32'h0000_0005);
    check("R6 irq kept without bit 9", 32'(irq), 32'd1);
    wr(7, 32'h0000_0200);
    check("R6 irq lowered", 32'(irq), 32'd0);
    rd(7, v); check("R6 status after clear", v, 32'd0);
  endtask

  task automatic t_cipher();
    logic [31:0] v;
    wr(4, 32'h1234_5678);
    check("R9 no start", 32'(start), 32'd0);
    rd(4, v); check("R9 stored", v, 32'h1234_5678);
  endtask

  task automatic t_oob();
    logic [31:0] v;
    wr(8, 32'h0000_0011);
    wr(24, 32'h0000_AAAA);
    rd(8, v);  check("R10 alias untouched", v, 32'h0000_0011);
    rd(24, v); check("R10 oob read 24", v, 32'd0);
    rd(63, v); check("R10 oob read 63", v, 32'd0);
  endtask

  task automatic t_busy();
    @(negedge clk); eng_busy = 1'b1;
    cmd_nostart("R11 busy", 32'h0000_0040, 32'h0000_0040);
    @(negedge clk); eng_busy = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_masks();
    t_primary();
    t_family();
    t_done();
    t_cipher();
    t_oob();
    t_busy();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule